// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block saves a selected set of processor registers onto a downward-growing stack in memory, or restores them from it, one 32-bit word per memory access. A start pulse carries the direction, an 8-bit selection mask and the current stack pointer. The block then reads the register file and issues stores, or issues loads and writes the register file, through a single-outstanding request/acknowledge memory port. When every selected register has been moved, it returns the new stack pointer and pulses done.

Four mask bits each select one register. One further bit selects a fixed group of seven registers, and that group also owns one empty 4-byte stack slot. The order of a restore is the exact mirror of the order of a save, so a restore undoes a save made with the same mask.

Register file index encoding used on the rf ports: 0 = D0, 1 = D1, 2 = D2, 3 = D3, 4 = A0, 5 = A1, 6 = A2, 7 = A3, 8 = MDR, 9 = LIR, 10 = LAR.

Top module: `stack_xfer_seq`

## Requirements
- R1: Mask bit 7 selects D2, bit 6 D3, bit 5 A2, bit 4 A3, and bit 3 the group {D0, D1, A0, A1, MDR, LIR, LAR}. Bits 2..0 have no effect on any access or on the returned stack pointer.
- R2: On a push (dir_pop = 0), each store goes to the current pointer minus 4, with mem_we = 1. The pointer is lowered before each store. The order is D2, D3, A2, A3, then the group as D0, D1, A0, A1, MDR, LIR, LAR. Each store's data is the register file word of that register.
- R3: When the group is pushed, the pointer drops by another 4 after the LAR store, with no memory access for that slot.
- R4: On a pop (dir_pop = 1) with the group selected, the pointer first rises by 4 with no access. Then loads are taken in the order LAR, LIR, MDR, A1, A0, D1, D0, then A3, A2, D3, D2 for the selected registers. Each load reads from the current pointer, and the pointer rises by 4 after each load. mem_we = 0.
- R5: On a pop, rf_we is high exactly in the cycle where a load is acknowledged. In that cycle rf_waddr is the register index and rf_wdata is mem_rdata.
- R6: sp_out is updated once, when the operation ends, to the input pointer minus (push) or plus (pop) 4 times the number of selected slots. The group counts as 8 slots. done is high for that one cycle, and busy is low in it.
- R7: At most one memory request is outstanding. A request holds mem_addr and mem_wdata stable until mem_ack is seen. Addresses are word aligned when the input pointer is.
- R8: A start whose mask has none of bits 7..3 set makes no memory access. done rises in the cycle after start, with sp_out equal to the input pointer.
- R9: A start pulse received while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| dir_pop | input | 1 | 1 = restore from stack, 0 = save to stack |
| sel_mask | input | 8 | Register selection mask |
| sp_in | input | 32 | Stack pointer at start |
| sp_out | output | 32 | Stack pointer after the last completed operation |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ack |
| mem_ack | input | 1 | Request accepted / load data valid |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |

## Verification
The hardest case to reach is the empty group slot. It is the only pointer movement with no memory access, so it shows only as a 4-byte offset in later addresses (pop) or in the final pointer (push). The stimulus pairs group-only masks in both directions, plus full masks, against a model that places that slot explicitly. Random acknowledge delays of zero to several cycles test that address and data are held. A second start driven in the middle of a busy operation, with a different mask and direction, must leave the access trace unchanged.

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq #(
  parameter int DW  = 32,
  parameter int AW  = 32,
  parameter int RIW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           dir_pop,
  input  logic [7:0]     sel_mask,
  input  logic [AW-1:0]  sp_in,
  output logic [AW-1:0]  sp_out,
  output logic           done,
  output logic           busy,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack,
  output logic [RIW-1:0] rf_raddr,
  input  logic [DW-1:0]  rf_rdata,
  output logic           rf_we,
  output logic [RIW-1:0] rf_waddr,
  output logic [DW-1:0]  rf_wdata
);
  localparam int NSLOT = 12;
  localparam int GAP   = NSLOT - 1;
  localparam int SW    = $clog2(NSLOT);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  function automatic logic [RIW-1:0] slot_reg(input logic [SW-1:0] s);
    case (s)
      4'd0:    slot_reg = RIW'(2);
      4'd1:    slot_reg = RIW'(3);
      4'd2:    slot_reg = RIW'(6);
      4'd3:    slot_reg = RIW'(7);
      4'd4:    slot_reg = RIW'(0);
      4'd5:    slot_reg = RIW'(1);
      4'd6:    slot_reg = RIW'(4);
      4'd7:    slot_reg = RIW'(5);
      4'd8:    slot_reg = RIW'(8);
      4'd9:    slot_reg = RIW'(9);
      4'd10:   slot_reg = RIW'(10);
      default: slot_reg = RIW'(0);
    endcase
  endfunction

  logic             pop_q;
  logic [NSLOT-1:0] pend_q;
  logic [AW-1:0]    sp_q;
  logic [SW-1:0]    cur;
  logic [NSLOT-1:0] en_in, pend_nx;
  logic [AW-1:0]    sp_nx;
  logic             cur_gap, adv;

  assign en_in = {{8{sel_mask[3]}}, sel_mask[4], sel_mask[5], sel_mask[6], sel_mask[7]};

  always_comb begin
    cur = '0;
    if (pop_q) begin
      for (int k = 0; k < NSLOT; k++)
        if (pend_q[k]) cur = SW'(k);
    end else begin
      for (int k = NSLOT - 1; k >= 0; k--)
        if (pend_q[k]) cur = SW'(k);
    end
  end

  assign cur_gap  = (cur == SW'(GAP));
  assign mem_req  = busy && !cur_gap;
  assign mem_we   = mem_req && !pop_q;
  assign mem_addr = pop_q ? sp_q : sp_q - STEP;
  assign mem_wdata = rf_rdata;
  assign rf_raddr = slot_reg(cur);
  assign rf_waddr = slot_reg(cur);
  assign rf_we    = mem_req && pop_q && mem_ack;
  assign rf_wdata = mem_rdata;
  assign adv      = busy && (cur_gap || mem_ack);
  assign sp_nx    = pop_q ? sp_q + STEP : sp_q - STEP;
  assign pend_nx  = pend_q & ~(NSLOT'(1) << cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      pop_q  <= 1'b0;
      pend_q <= '0;
      sp_q   <= '0;
      sp_out <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        if (en_in == '0) begin
          done   <= 1'b1;
          sp_out <= sp_in;
        end else begin
          busy   <= 1'b1;
          pop_q  <= dir_pop;
          pend_q <= en_in;
          sp_q   <= sp_in;
        end
      end else if (adv) begin
        sp_q   <= sp_nx;
        pend_q <= pend_nx;
        if (pend_nx == '0) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          sp_out <= sp_nx;
        end
      end
    end
  end
endmodule

module stack_xfer_seq_chk #(
  parameter int DW  = 32,
  parameter int AW  = 32,
  parameter int RIW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [AW-1:0] sp_in,
  input logic          rf_we
);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_rf_write_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_req && mem_ack && !mem_we));
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
  assert_req_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && sp_in[1:0] == 2'b00 && $stable(sp_in)) |-> (mem_addr[1:0] == 2'b00));
endmodule

bind stack_xfer_seq stack_xfer_seq_chk #(.DW(DW), .AW(AW), .RIW(RIW)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .sp_in(sp_in), .rf_we(rf_we)
);

// File: tb/stack_xfer_seq_tb.sv
module stack_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_pop = 1'b0;
  logic [7:0]  sel_mask = '0;
  logic [31:0] sp_in = '0;
  logic [31:0] sp_out, mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic        done, busy, mem_req, mem_we, rf_we;
  logic        mem_ack = 1'b0;
  logic [3:0]  rf_raddr, rf_waddr;

  always #10 clk = ~clk;

  stack_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_pop(dir_pop), .sel_mask(sel_mask),
    .sp_in(sp_in), .sp_out(sp_out), .done(done), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  assign rf_rdata  = 32'hC0DE_0000 | {28'd0, rf_raddr};
  assign mem_rdata = mem_addr ^ 32'h5A5A_0F0F;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  int          log_n;
  logic [31:0] log_addr [16];
  logic [31:0] log_wdata [16];
  logic        log_we [16];
  logic [3:0]  log_ridx [16];
  logic        log_rfwe [16];
  logic [3:0]  log_widx [16];
  logic [31:0] log_wd [16];
  int          wait_cnt = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_ack  <= 1'b1;
        wait_cnt <= int'($urandom % 4);
      end else wait_cnt <= wait_cnt - 1;
    end
    if (mem_req && mem_ack && log_n < 16) begin
      log_addr[log_n]  <= mem_addr;
      log_wdata[log_n] <= mem_wdata;
      log_we[log_n]    <= mem_we;
      log_ridx[log_n]  <= rf_raddr;
      log_rfwe[log_n]  <= rf_we;
      log_widx[log_n]  <= rf_waddr;
      log_wd[log_n]    <= rf_wdata;
      log_n <= log_n + 1;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(negedge clk) if (cyc > 150000 && !finished) begin
    checks++; fails++;
    $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
    summary();
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] slot_idx(input int k);
    case (k)
      0: return 4'd2;  1: return 4'd3;  2: return 4'd6;  3: return 4'd7;
      4: return 4'd0;  5: return 4'd1;  6: return 4'd4;  7: return 4'd5;
      8: return 4'd8;  9: return 4'd9;  default: return 4'd10;
    endcase
  endfunction

  function automatic bit slot_en(input logic [7:0] m, input int k);
    case (k)
      0: return m[7];
      1: return m[6];
      2: return m[5];
      3: return m[4];
      default: return m[3];
    endcase
  endfunction

  int          e_n;
  logic [31:0] e_addr [16];
  logic [3:0]  e_idx [16];
  logic [31:0] e_sp;

  task automatic model(input logic [7:0] m, input bit pop, input logic [31:0] sp);
    logic [31:0] s = sp;
    e_n = 0;
    if (!pop) begin
      for (int k = 0; k < 12; k++) if (slot_en(m, k)) begin
        s = s - 4;
        if (k < 11) begin e_addr[e_n] = s; e_idx[e_n] = slot_idx(k); e_n++; end
      end
    end else begin
      for (int k = 11; k >= 0; k--) if (slot_en(m, k)) begin
        if (k < 11) begin e_addr[e_n] = s; e_idx[e_n] = slot_idx(k); e_n++; end
        s = s + 4;
      end
    end
    e_sp = s;
  endtask

  task automatic run_op(input logic [7:0] m, input bit pop, input logic [31:0] sp, input bit poke);
    int n;
    bit got;
    model(m, pop, sp);
    @(negedge clk);
    log_n = 0;
    sel_mask = m; dir_pop = pop; sp_in = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    got = done;
    if (poke && !got) begin
      sel_mask = ~m; dir_pop = ~pop; sp_in = sp ^ 32'h0000_1000; start = 1'b1;
      @(negedge clk);
      start = 1'b0; n++;
      got = done;
    end
    while (!got && n < 400) begin
      @(negedge clk);
      n++;
      got = done;
    end
    chk(got, "R6 done seen", 32'(got), 32'd1);
    if (e_n == 0 && !poke) chk(n == 1, "R8 one-cycle completion", 32'(n), 32'd1);
    chk(sp_out == e_sp, pop ? "R4 final pointer" : "R3 final pointer", sp_out, e_sp);
    chk(log_n == e_n, poke ? "R9 access count" : "R1 access count", 32'(log_n), 32'(e_n));
    for (int i = 0; i < e_n && i < log_n; i++) begin
      chk(log_addr[i] == e_addr[i], pop ? "R4 address" : "R2 address", log_addr[i], e_addr[i]);
      chk(log_we[i] == !pop, "R2 write enable", 32'(log_we[i]), 32'(!pop));
      if (!pop) begin
        chk(log_ridx[i] == e_idx[i], "R2 register order", 32'(log_ridx[i]), 32'(e_idx[i]));
        chk(log_wdata[i] == (32'hC0DE_0000 | {28'd0, e_idx[i]}), "R2 store data",
            log_wdata[i], 32'hC0DE_0000 | {28'd0, e_idx[i]});
        chk(!log_rfwe[i], "R5 no rf write on push", 32'(log_rfwe[i]), 32'd0);
      end else begin
        chk(log_rfwe[i], "R5 rf write on ack", 32'(log_rfwe[i]), 32'd1);
        chk(log_widx[i] == e_idx[i], "R4 register order", 32'(log_widx[i]), 32'(e_idx[i]));
        chk(log_wd[i] == (e_addr[i] ^ 32'h5A5A_0F0F), "R5 load data",
            log_wd[i], e_addr[i] ^ 32'h5A5A_0F0F);
      end
    end
    @(negedge clk);
    chk(!done, "R6 done pulse width", 32'(done), 32'd0);
    chk(!busy, "R6 idle after done", 32'(busy), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    log_n = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we, "R6 reset state",
        {28'd0, busy, done, mem_req, rf_we}, 32'd0);
    rst_n = 1'b1;
    run_op(8'h00, 1'b0, 32'h0000_8000, 1'b0);
    run_op(8'h07, 1'b1, 32'h0000_8000, 1'b0);
    run_op(8'hF0, 1'b0, 32'h0000_8000, 1'b0);
    run_op(8'h08, 1'b0, 32'h0000_8000, 1'b0);
    run_op(8'h08, 1'b1, 32'h0000_7FE0, 1'b0);
    run_op(8'hFF, 1'b0, 32'h0001_0000, 1'b0);
    run_op(8'hFF, 1'b1, 32'h0000_FFD0, 1'b0);
    run_op(8'hA8, 1'b1, 32'h0000_0004, 1'b0);
    run_op(8'h58, 1'b0, 32'h0000_2000, 1'b1);
    run_op(8'h90, 1'b1, 32'h0000_3000, 1'b1);
    for (int t = 0; t < 60; t++) begin
      logic [7:0] m = 8'($urandom);
      logic [31:0] sp = {$urandom, 2'b00};
      run_op(m, 1'($urandom), sp, (t % 5) == 0);
    end
    summary();
  end
endmodule